// File: doc/BRIEF.md
# Chip-Select Serviced Watchdog Timer

This block supervises a processor by watching its chip-select line. Each falling edge of chip select counts as one service and restarts the timeout count. If no falling edge arrives within the selected period, the active-low watchdog output goes low. It stays low until the next falling edge, which releases it and starts a new period.

A 2-bit period field chooses among three timeout lengths or turns the watchdog off. Software writes this field into a status register elsewhere in the chip, and it reaches this block as an input. The count runs on a slow tick taken from a prescaled system clock. The tick stops while the device runs from its backup battery and starts again when main power returns. Writing a new period value, or choosing off, clears the count and releases the output.

Top module: `wdt_cs_monitor`

## Requirements
- R1: A falling edge of `cs_n_i` (high to low, after synchronization) clears the count, so the timeout is measured again in full from that edge.
- R2: While `cs_n_i` is held low, no further service is counted, and the watchdog expires one period after the single falling edge.
- R3: With `period_sel_i` = 2'b00, `wdo_n_o` goes low about P0_TICKS×PRESCALE clock cycles after the last falling edge.
- R4: With `period_sel_i` = 2'b01 the period is P1_TICKS ticks, and with 2'b10 it is P2_TICKS ticks, each tick being PRESCALE clock cycles.
- R5: With `period_sel_i` = 2'b11 the watchdog is off, and `wdo_n_o` stays high for any length of time without service.
- R6: Once `wdo_n_o` is low it stays low until the next falling edge of chip select, which drives it high again within a few cycles.
- R7: While `backup_i` is high the timebase and the count are frozen, and `wdo_n_o` holds its value. Counting resumes from the frozen point when `backup_i` falls.
- R8: A change of `period_sel_i` clears the count and releases `wdo_n_o`.
- R9: After reset `wdo_n_o` is high and the count starts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip select from the processor, asynchronous; its falling edges service the watchdog |
| period_sel_i | input | 2 | Period code: 00 short, 01 middle, 10 long, 11 off |
| backup_i | input | 1 | High while running on the backup battery; freezes the timebase |
| wdo_n_o | output | 1 | Watchdog output, low while a timeout is pending service |

## Verification
The hardest case to reach is a backup interval that falls in the middle of a running period. There the count must resume from where it stopped, not from zero, and not count as having expired. The bench services the watchdog, lets part of the period pass, and holds backup high much longer than the whole period. It then shows that the output is still high shortly after backup ends, and that it falls only once the remaining part of the period has elapsed. Expiry while chip select is held low is reached the same way, by driving a single falling edge and never raising the line again.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    WDT_SHORT  = 2'b00,
    WDT_MIDDLE = 2'b01,
    WDT_LONG   = 2'b10,
    WDT_OFF    = 2'b11
  } wdt_period_e;
endpackage

// File: rtl/wdt_edge_sync.sv
module wdt_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic async_i,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic prev_q, prev_d;
  logic fall_q, fall_d;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], async_i};
    prev_d = sync_q[SYNC_STAGES-1];
    fall_d = prev_q & ~sync_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= '1;
      prev_q <= 1'b1;
      fall_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
      fall_q <= fall_d;
    end
  end

  assign fall_o = fall_q;

  // R2: a single edge yields one pulse, never two in a row
  assert_single_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    fall_o |=> !fall_o);
endmodule

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
  parameter int PRESCALE = 50000
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic run_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int PW = $clog2(PRESCALE + 1);
  localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] pre_q, pre_d;
  logic          pre_en;
  logic          wrap;

  always_comb begin
    wrap   = (pre_q == PRE_LAST);
    pre_en = clr_i | run_i;
    if (clr_i)     pre_d = '0;
    else if (wrap) pre_d = '0;
    else           pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)    pre_q <= '0;
    else if (pre_en) pre_q <= pre_d;
  end

  assign tick_o = run_i & ~clr_i & wrap;

  // R7: the prescaler does not move while frozen
  assert_pre_frozen_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!run_i && !clr_i) |=> $stable(pre_q));
endmodule

// File: rtl/wdt_count.sv
module wdt_count
  import wdt_pkg::*;
#(
  parameter int P0_TICKS = 150,
  parameter int P1_TICKS = 400,
  parameter int P2_TICKS = 800
) (
  input  logic       clk_i,
  input  logic       rst_n_i,
  input  logic       tick_i,
  input  logic       kick_i,
  input  logic [1:0] period_sel_i,
  output logic       restart_o,
  output logic       wdo_n_o
);
  localparam int MAXP = (P0_TICKS > P1_TICKS) ?
                        ((P0_TICKS > P2_TICKS) ? P0_TICKS : P2_TICKS) :
                        ((P1_TICKS > P2_TICKS) ? P1_TICKS : P2_TICKS);
  localparam int CW = $clog2(MAXP + 1);
  localparam logic [CW-1:0] L0 = CW'(P0_TICKS - 1);
  localparam logic [CW-1:0] L1 = CW'(P1_TICKS - 1);
  localparam logic [CW-1:0] L2 = CW'(P2_TICKS - 1);

  wdt_period_e   sel;
  logic [1:0]    sel_q;
  logic          sel_chg;
  logic          off;
  logic [CW-1:0] last;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wdo_q, wdo_d;
  logic          cnt_en;

  always_comb begin
    sel     = wdt_period_e'(period_sel_i);
    sel_chg = (period_sel_i != sel_q);
    off     = (sel == WDT_OFF);
    unique case (sel)
      WDT_SHORT:  last = L0;
      WDT_MIDDLE: last = L1;
      WDT_LONG:   last = L2;
      default:    last = '0;
    endcase
  end

  assign restart_o = kick_i | sel_chg | off;

  always_comb begin
    cnt_d  = cnt_q;
    wdo_d  = wdo_q;
    cnt_en = restart_o | (tick_i & wdo_q);
    if (restart_o) begin
      cnt_d = '0;
      wdo_d = 1'b1;
    end else if (tick_i && wdo_q) begin
      if (cnt_q == last) begin
        cnt_d = '0;
        wdo_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cnt_q <= '0;
      wdo_q <= 1'b1;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      wdo_q <= wdo_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) sel_q <= 2'b00;
    else          sel_q <= period_sel_i;
  end

  assign wdo_n_o = wdo_q;

  // R6: a service edge releases the output on the next cycle
  assert_kick_release_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    kick_i |=> wdo_n_o);
  // R5: the off code keeps the output released
  assert_off_released_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (period_sel_i == 2'b11) |=> wdo_n_o);
  // R8: a new period code releases the output
  assert_selchg_release_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (period_sel_i != $past(period_sel_i)) |-> ##1 wdo_n_o);
  // R3: the output only falls after a timebase tick
  assert_fall_on_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $fell(wdo_n_o) |-> $past(tick_i));
endmodule

// File: rtl/wdt_cs_monitor.sv
module wdt_cs_monitor #(
  parameter int PRESCALE    = 50000,
  parameter int P0_TICKS    = 150,
  parameter int P1_TICKS    = 400,
  parameter int P2_TICKS    = 800,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_n_i,
  input  logic       cs_n_i,
  input  logic [1:0] period_sel_i,
  input  logic       backup_i,
  output logic       wdo_n_o
);
  logic kick;
  logic tick;
  logic restart;

  wdt_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .async_i (cs_n_i),
    .fall_o  (kick)
  );

  wdt_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .run_i   (~backup_i),
    .clr_i   (restart),
    .tick_o  (tick)
  );

  wdt_count #(
    .P0_TICKS(P0_TICKS),
    .P1_TICKS(P1_TICKS),
    .P2_TICKS(P2_TICKS)
  ) u_count (
    .clk_i        (clk_i),
    .rst_n_i      (rst_n_i),
    .tick_i       (tick),
    .kick_i       (kick),
    .period_sel_i (period_sel_i),
    .restart_o    (restart),
    .wdo_n_o      (wdo_n_o)
  );

  // R7: in backup with no restart, the output holds
  assert_backup_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (backup_i && !restart) |=> $stable(wdo_n_o));
endmodule

// File: tb/wdt_cs_monitor_tb.sv
module wdt_cs_monitor_tb_top;
  localparam int PS = 4;
  localparam int T0 = 10;
  localparam int T1 = 20;
  localparam int T2 = 40;

  logic       clk;
  logic       rst_n;
  logic       cs_n;
  logic [1:0] sel;
  logic       backup;
  logic       wdo_n;

  int checks;
  int errors;

  wdt_cs_monitor #(.PRESCALE(PS), .P0_TICKS(T0), .P1_TICKS(T1), .P2_TICKS(T2)) dut_i (
    .clk_i        (clk),
    .rst_n_i      (rst_n),
    .cs_n_i       (cs_n),
    .period_sel_i (sel),
    .backup_i     (backup),
    .wdo_n_o      (wdo_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: wdo_n=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // one falling edge of chip select, leaving it low
  task automatic kick_low();
    cs_n = 1'b1;
    wait_cyc(3);
    cs_n = 1'b0;
  endtask

  task automatic kick();
    kick_low();
    wait_cyc(2);
    cs_n = 1'b1;
  endtask

  task automatic t_reset();
    check("R9 reset", wdo_n, 1'b1);
  endtask

  task automatic t_period(input logic [1:0] code, input int ticks, input string tag);
    sel = code;
    wait_cyc(2);
    kick_low();
    wait_cyc(ticks * PS - 6);
    check({tag, " before expiry"}, wdo_n, 1'b1);
    wait_cyc(14);
    check({tag, " after expiry"}, wdo_n, 1'b0);
    cs_n = 1'b1;
    wait_cyc(3);
  endtask

  task automatic t_held_low();
    sel = 2'b00;
    wait_cyc(2);
    kick_low();
    wait_cyc(T0 * PS + 8);
    check("R2 held low expires", wdo_n, 1'b0);
    wait_cyc(3 * T0 * PS);
    check("R6 stays low", wdo_n, 1'b0);
    cs_n = 1'b1;
    wait_cyc(3);
    cs_n = 1'b0;
    wait_cyc(6);
    check("R6 edge releases", wdo_n, 1'b1);
    cs_n = 1'b1;
  endtask

  task automatic t_restart();
    sel = 2'b00;
    wait_cyc(2);
    kick();
    for (int k = 0; k < 6; k++) begin
      wait_cyc(T0 * PS - 15);
      kick();
    end
    wait_cyc(T0 * PS - 12);
    check("R1 periodic service keeps high", wdo_n, 1'b1);
    wait_cyc(20);
    check("R1 expiry after last service", wdo_n, 1'b0);
    kick();
  endtask

  task automatic t_off();
    sel = 2'b11;
    wait_cyc(T2 * PS * 3);
    check("R5 off never asserts", wdo_n, 1'b1);
    sel = 2'b00;
    kick_low();
    wait_cyc(T0 * PS + 8);
    check("R5 expired before off", wdo_n, 1'b0);
    sel = 2'b11;
    wait_cyc(2);
    check("R5 off releases", wdo_n, 1'b1);
    cs_n = 1'b1;
  endtask

  task automatic t_selchg();
    sel = 2'b00;
    wait_cyc(2);
    kick_low();
    wait_cyc(T0 * PS + 8);
    check("R8 expired", wdo_n, 1'b0);
    sel = 2'b01;
    wait_cyc(2);
    check("R8 change releases", wdo_n, 1'b1);
    wait_cyc(T1 * PS - 8);
    check("R8 count restarted", wdo_n, 1'b1);
    wait_cyc(14);
    check("R8 new period expires", wdo_n, 1'b0);
    cs_n = 1'b1;
    wait_cyc(3);
  endtask

  task automatic t_backup();
    sel = 2'b00;
    wait_cyc(2);
    kick_low();
    wait_cyc(T0 * PS / 2);
    backup = 1'b1;
    wait_cyc(T0 * PS * 4);
    check("R7 frozen in backup", wdo_n, 1'b1);
    backup = 1'b0;
    wait_cyc(T0 * PS / 2 - 8);
    check("R7 resumed not expired", wdo_n, 1'b1);
    wait_cyc(16);
    check("R7 expires after remainder", wdo_n, 1'b0);
    backup = 1'b1;
    wait_cyc(50);
    check("R7 expired held in backup", wdo_n, 1'b0);
    backup = 1'b0;
    cs_n = 1'b1;
  endtask

  initial begin
    checks = 0;
    errors = 0;
    rst_n  = 1'b0;
    cs_n   = 1'b1;
    sel    = 2'b00;
    backup = 1'b0;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(2);
    t_reset();
    t_period(2'b00, T0, "R3 code00");
    t_period(2'b01, T1, "R4 code01");
    t_period(2'b10, T2, "R4 code10");
    t_held_low();
    t_restart();
    t_off();
    t_selchg();
    t_backup();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish, act hung exp done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule